// File: doc/BRIEF.md
# Eight-Channel Converter and Threshold Comparator Controller

This block is the digital half of an eight-channel analog front end. Each channel is set up on its own either as a 10-bit successive-approximation converter or as a single-threshold comparator. The block holds a small register file that software reads and writes one byte at a time. From that it drives a 10-bit code into an external resistor ladder, picks the analog channel, and samples the single output bit of the external comparator. The analog parts are outside the block.

A run starts when software writes the control word with its start bit set. A converter channel then resolves its input over ten trial steps, most significant bit first. Each step advances on one pulse of the selected conversion clock. The result is packed into the channel's even and odd result bytes as 10-bit or 8-bit data. A comparator channel places its stored even byte, followed by binary 10, on the ladder. After one conversion-clock step it records whether the input is at or above that level in the channel's bit of the comparator result byte.

The conversion clock is a one-cycle enable pulse. It is chosen from prescaled enables (every 2, 4 or 8 system clocks) or from the system clock itself. The ladder reference can be cut off, and a run waits one microsecond after the reference is reconnected before it begins. If software disconnects the reference during a run, the run is abandoned and no result is stored.

Top module: `adc_cmp_ctrl`

## Requirements
- R1: After reset, control word 0 (address 0x00) and the mode byte (0x02) read 0x00. Control word 1 (0x01) reads 0x20, with the disconnect bit 5 set. `busy` and `ladder_en` are 0.
- R2: Bit i of the mode byte (0x02) puts channel i in comparator mode when 1 and converter mode when 0. A comparator run leaves the channel's result bytes unchanged. A converter run leaves the comparator result byte (0x03) unchanged.
- R3: During a comparator run, `dac_code` equals the channel's even result byte in bits 9..2 and binary 10 in bits 1..0.
- R4: A comparator run sets bit i of 0x03 to 1 when `cmp_in` is 1 at the sampling pulse and clears it to 0 otherwise. `cmp_in` is 1 when the input is at or above the ladder level.
- R5: A converter run performs ten trial steps from bit 9 down to bit 0. Each step keeps its trial bit when `cmp_in` is 1, so the result is the largest code not above the input.
- R6: With control word 1 bit 3 set (10-bit mode), the even byte at 0x10+2i holds result bits 7..0. The odd byte at 0x11+2i holds result bits 9..8 in bits 1..0, and its bits 7..2 read 0.
- R7: With control word 1 bit 3 clear (8-bit mode), the even byte holds result bits 9..2 and the odd byte reads 0x00.
- R8: The conversion clock is selected by {control word 1 bit 4, control word 0 bit 7}: 00 selects the divide-by-8 pulse, 01 divide-by-4, 10 divide-by-2, and 11 the system clock itself. Each trial step consumes one pulse of the selected clock.
- R9: With select 11 in 10-bit mode, the divide-by-2 pulse is used instead of the system clock.
- R10: `ladder_en` is the inverse of control word 1 bit 5. A started run stays pending, with `busy` high, until `ladder_en` has been high for ceil(CLK_HZ/1e6) cycles.
- R11: While `busy` is high, writes to control word 0, the mode byte and the result bytes are ignored. Bit 6 of control word 0 is the start bit on write and reads back as `busy`. Control word 0 bits 2..0 pick the channel.
- R12: `dac_code` is zero whenever no run is in its trial phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf2_tick | input | 1 | One-cycle enable every 2 system clocks |
| pf4_tick | input | 1 | One-cycle enable every 4 system clocks |
| pf8_tick | input | 1 | One-cycle enable every 8 system clocks |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cmp_in | input | 1 | External comparator output, 1 when input is at or above the ladder level |
| dac_code | output | 10 | Code driven to the ladder |
| chan_sel | output | 3 | Selected analog channel |
| ladder_en | output | 1 | Reference connected to the ladder |
| busy | output | 1 | Run pending or in progress |

## Verification
The assertions assume that each prescaled enable is a single-cycle pulse. They also assume that `cmp_in` only needs to be valid in the cycle where a pulse is taken. The bench derives all three enables from one free-running counter, so they are periodic single pulses. Its analog model compares the selected channel's stored input level with `dac_code` combinationally. Register traffic is driven between clock edges. The bench issues no register writes while a run is in progress, except the deliberate writes that test R11.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  localparam int unsigned CODE_W = 10;
  localparam logic [4:0] A_CTRL0  = 5'h00;
  localparam logic [4:0] A_CTRL1  = 5'h01;
  localparam logic [4:0] A_MODE   = 5'h02;
  localparam logic [4:0] A_CMPRES = 5'h03;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_RUN} run_state_t;
endpackage

// File: rtl/adc_tick_sel.sv
module adc_tick_sel (
  input  logic pf2_tick,
  input  logic pf4_tick,
  input  logic pf8_tick,
  input  logic sel_hi,
  input  logic sel_lo,
  input  logic res10,
  output logic tick
);
  always_comb begin
    unique case ({sel_hi, sel_lo})
      2'b00:   tick = pf8_tick;
      2'b01:   tick = pf4_tick;
      2'b10:   tick = pf2_tick;
      default: tick = res10 ? pf2_tick : 1'b1;
    endcase
  end
endmodule

// File: rtl/adc_settle.sv
module adc_settle #(
  parameter int unsigned SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ladder_off,
  output logic settled
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= LOAD;
    else if (ladder_off)      cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign settled = !ladder_off && (cnt_q == '0);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_cmp_pkg::*;
#(
  parameter int unsigned BITS = CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ready,
  input  logic            cmp_mode,
  input  logic [BITS-3:0] thresh,
  input  logic            tick,
  input  logic            cmp_in,
  output logic            busy,
  output logic            running,
  output logic            done,
  output logic [BITS-1:0] fin_val,
  output logic [BITS-1:0] dac_code
);
  localparam int unsigned STEP_W = $clog2(BITS);
  localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(BITS - 1);

  run_state_t        state_q;
  logic [BITS-1:0]   acc_q;
  logic [STEP_W-1:0] step_q;
  logic [BITS-1:0]   trial_bit;

  assign trial_bit = BITS'(1) << step_q;
  assign busy      = (state_q != ST_IDLE);
  assign running   = (state_q == ST_RUN);
  assign done      = running && ready && tick && (cmp_mode || step_q == '0);
  assign fin_val   = cmp_in ? (acc_q | trial_bit) : acc_q;

  always_comb begin
    if (!running)     dac_code = '0;
    else if (cmp_mode) dac_code = {thresh, 2'b10};
    else              dac_code = acc_q | trial_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_PEND;
        ST_PEND: if (ready) begin
          state_q <= ST_RUN;
          acc_q   <= '0;
          step_q  <= TOP_STEP;
        end
        ST_RUN: begin
          if (!ready) state_q <= ST_IDLE;
          else if (tick) begin
            if (cmp_in) acc_q <= acc_q | trial_bit;
            if (cmp_mode || step_q == '0) state_q <= ST_IDLE;
            else step_q <= step_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_cmp_ctrl.sv
module adc_cmp_ctrl
  import adc_cmp_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pf2_tick,
  input  logic                     pf4_tick,
  input  logic                     pf8_tick,
  input  logic                     reg_wr,
  input  logic [4:0]               reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic                     cmp_in,
  output logic [CODE_W-1:0]        dac_code,
  output logic [$clog2(NCH)-1:0]   chan_sel,
  output logic                     ladder_en,
  output logic                     busy
);
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam int unsigned SETTLE = (CLK_HZ + 999_999) / 1_000_000;

  // control state
  logic            sel_lo_q, sel_hi_q, res10_q, ladder_off_q;
  logic [CH_W-1:0] chan_q;
  logic [NCH-1:0]  mode_q, cmpres_q;
  logic [7:0]      even_q [NCH];
  logic [1:0]      odd_q  [NCH];

  logic conv_tick, settled, running, done, run_cmp, wr_free, start;
  logic [CODE_W-1:0] fin_val;
  logic              res_area;
  logic [CH_W-1:0]   addr_ch;

  assign wr_free  = reg_wr && !busy;
  assign start    = wr_free && (reg_addr == A_CTRL0) && reg_wdata[6];
  assign run_cmp  = mode_q[chan_q];
  assign res_area = reg_addr[4] && (int'(reg_addr[3:1]) < NCH);
  assign addr_ch  = CH_W'(reg_addr[3:1]);
  assign chan_sel = chan_q;
  assign ladder_en = !ladder_off_q;

  adc_tick_sel u_tick (
    .pf2_tick (pf2_tick),
    .pf4_tick (pf4_tick),
    .pf8_tick (pf8_tick),
    .sel_hi   (sel_hi_q),
    .sel_lo   (sel_lo_q),
    .res10    (res10_q),
    .tick     (conv_tick)
  );

  adc_settle #(.SETTLE_CYC(SETTLE)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .ladder_off (ladder_off_q),
    .settled    (settled)
  );

  adc_sar_core #(.BITS(CODE_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (settled),
    .cmp_mode (run_cmp),
    .thresh   (even_q[chan_q]),
    .tick     (conv_tick),
    .cmp_in   (cmp_in),
    .busy     (busy),
    .running  (running),
    .done     (done),
    .fin_val  (fin_val),
    .dac_code (dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo_q     <= 1'b0;
      chan_q       <= '0;
      sel_hi_q     <= 1'b0;
      res10_q      <= 1'b0;
      ladder_off_q <= 1'b1;
      mode_q       <= '0;
    end else begin
      if (wr_free && reg_addr == A_CTRL0) begin
        sel_lo_q <= reg_wdata[7];
        chan_q   <= CH_W'(reg_wdata[2:0]);
      end
      if (reg_wr && reg_addr == A_CTRL1) begin
        res10_q      <= reg_wdata[3];
        sel_hi_q     <= reg_wdata[4];
        ladder_off_q <= reg_wdata[5];
      end
      if (wr_free && reg_addr == A_MODE) mode_q <= reg_wdata[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic store_adc, wr_even, wr_odd;
    assign store_adc = done && (chan_q == CH_W'(g)) && !mode_q[g];
    assign wr_even   = wr_free && res_area && (addr_ch == CH_W'(g)) && !reg_addr[0];
    assign wr_odd    = wr_free && res_area && (addr_ch == CH_W'(g)) &&  reg_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        even_q[g]   <= '0;
        odd_q[g]    <= '0;
        cmpres_q[g] <= 1'b0;
      end else begin
        if (store_adc) begin
          if (res10_q) begin
            even_q[g] <= fin_val[7:0];
            odd_q[g]  <= fin_val[9:8];
          end else begin
            even_q[g] <= fin_val[9:2];
            odd_q[g]  <= 2'b00;
          end
        end else if (wr_even) begin
          even_q[g] <= reg_wdata;
        end else if (wr_odd) begin
          odd_q[g]  <= reg_wdata[1:0];
        end
        if (done && (chan_q == CH_W'(g)) && mode_q[g]) cmpres_q[g] <= cmp_in;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (res_area) begin
      reg_rdata = reg_addr[0] ? {6'b0, odd_q[addr_ch]} : even_q[addr_ch];
    end else begin
      unique case (reg_addr)
        A_CTRL0:  reg_rdata = {sel_lo_q, busy, 3'b000, 3'(chan_q)};
        A_CTRL1:  reg_rdata = {2'b00, ladder_off_q, sel_hi_q, res10_q, 3'b000};
        A_MODE:   reg_rdata = 8'(mode_q);
        A_CMPRES: reg_rdata = 8'(cmpres_q);
        default:  reg_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/adc_cmp_ctrl_chk.sv
module adc_cmp_ctrl_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           running,
  input logic           run_cmp,
  input logic           conv_tick,
  input logic           ladder_en,
  input logic           settled,
  input logic [9:0]     dac_code,
  input logic [NCH-1:0] mode_q
);
  a_r10_ladder_gate: assert property (@(posedge clk) disable iff (!rst_n)
    running && !ladder_en |=> !running);

  a_r10_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(settled));

  a_r3_cmp_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    running && run_cmp |-> dac_code[1:0] == 2'b10);

  a_r8_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && !$past(conv_tick) |-> $stable(dac_code));

  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode_q));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> dac_code == 10'd0);
endmodule

bind adc_cmp_ctrl adc_cmp_ctrl_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .running   (running),
  .run_cmp   (run_cmp),
  .conv_tick (conv_tick),
  .ladder_en (ladder_en),
  .settled   (settled),
  .dac_code  (dac_code),
  .mode_q    (mode_q)
);

// File: tb/adc_cmp_ctrl_tb_top.sv
module adc_cmp_ctrl_tb_top;
  typedef struct {
    logic [4:0] addr;
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cmp_in, ladder_en, busy;
  logic [9:0] dac_code;
  logic [2:0] chan_sel;
  logic [2:0] pc = '0;
  logic [9:0] ain [8];
  logic [9:0] dac_seen;

  int n_chk = 0, n_bad = 0;
  exp_t sb [$];

  always #5 clk = ~clk;
  always @(posedge clk) pc <= pc + 3'd1;

  assign cmp_in = (ain[chan_sel] >= dac_code);

  adc_cmp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .pf2_tick(pc[0]), .pf4_tick(pc[1:0] == 2'b11), .pf8_tick(pc == 3'b111),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
    .ladder_en(ladder_en), .busy(busy)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(string tag, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // start a run on channel ch; returns the number of cycles busy stayed high
  task automatic run(int ch, logic sel_lo, output int cyc);
    wr(5'h00, {sel_lo, 1'b1, 3'b000, 3'(ch)});
    cyc = 0;
    dac_seen = '0;
    while (busy && cyc < 5000) begin
      cyc++;
      if (dac_code != '0) dac_seen = dac_code;
      @(negedge clk);
    end
  endtask

  // driver side: push expected register contents after a converter run
  task automatic push_adc(int ch, logic [9:0] v, logic res10, string tag);
    exp_t e;
    e.addr = 5'(16 + 2*ch); e.val = res10 ? v[7:0] : v[9:2]; e.tag = tag; sb.push_back(e);
    e.addr = 5'(17 + 2*ch); e.val = res10 ? {6'b0, v[9:8]} : 8'h00; e.tag = tag; sb.push_back(e);
  endtask

  // monitor side: pop and compare against register reads
  task automatic drain();
    logic [7:0] d;
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      rd(e.addr, d);
      check(e.tag, d, e.val);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int cyc;
    for (int i = 0; i < 8; i++) ain[i] = 10'(i * 100 + 37);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h01, d); check("R1 ctrl1", d, 8'h20);
    rd(5'h00, d); check("R1 ctrl0", d, 8'h00);
    rd(5'h02, d); check("R1 mode", d, 8'h00);
    check("R1 busy", busy, 0);
    check("R1 ladder", ladder_en, 0);

    // R10: connect ladder and start at once; settle wait plus direct clock
    wr(5'h01, 8'h10);                      // flag1=1, 8-bit, ladder on
    check("R10 ladder_en", ladder_en, 1);
    ain[0] = 10'h2B7;
    run(0, 1'b1, cyc);
    check_rng("R10 settle delay", cyc, 105, 115);
    check("R12 idle code", dac_code, 0);
    push_adc(0, 10'h2B7, 1'b0, "R7 8-bit pack ch0");
    drain();

    // R8 direct clock in 8-bit mode, already settled
    ain[1] = 10'h155;
    run(1, 1'b1, cyc);
    check("R8 direct clock length", cyc, 11);
    push_adc(1, 10'h155, 1'b0, "R5 sar ch1");

    // R9 fallback in 10-bit mode
    wr(5'h01, 8'h18);
    ain[3] = 10'h3FF;
    run(3, 1'b1, cyc);
    check_rng("R9 fallback to div2", cyc, 19, 22);
    push_adc(3, 10'h3FF, 1'b1, "R6 10-bit pack ch3 full");
    drain();

    // R8 divide-by-8, -4, -2 in 10-bit mode; R5 patterns
    wr(5'h01, 8'h08);
    ain[4] = 10'h000;
    run(4, 1'b0, cyc);
    check_rng("R8 div8 length", cyc, 73, 82);
    push_adc(4, 10'h000, 1'b1, "R5 sar zero ch4");
    ain[6] = 10'h2AA;
    run(6, 1'b1, cyc);
    check_rng("R8 div4 length", cyc, 37, 42);
    push_adc(6, 10'h2AA, 1'b1, "R6 10-bit pack ch6");
    wr(5'h01, 8'h18);
    ain[7] = 10'h1C3;
    run(7, 1'b0, cyc);
    check_rng("R8 div2 length", cyc, 19, 22);
    push_adc(7, 10'h1C3, 1'b1, "R5 sar ch7");
    drain();

    // R2/R3/R4 comparator on channel 5, threshold 0x80 -> level 514
    wr(5'h1A, 8'h80);
    wr(5'h02, 8'h20);
    rd(5'h02, d); check("R2 mode write", d, 8'h20);
    ain[5] = 10'd514;
    run(5, 1'b1, cyc);
    check("R3 cmp dac code", dac_seen, 10'h202);
    rd(5'h03, d); check("R4 cmp at level", d, 8'h20);
    ain[5] = 10'd513;
    run(5, 1'b1, cyc);
    rd(5'h03, d); check("R4 cmp below", d, 8'h00);
    ain[5] = 10'd515;
    run(5, 1'b0, cyc);
    rd(5'h03, d); check("R4 cmp above", d, 8'h20);
    rd(5'h1A, d); check("R2 cmp keeps even byte", d, 8'h80);
    // R2: converter run on channel 2 leaves comparator byte alone
    ain[2] = 10'h0F0;
    run(2, 1'b1, cyc);
    rd(5'h03, d); check("R2 adc keeps cmp byte", d, 8'h20);
    push_adc(2, 10'h0F0, 1'b1, "R2 adc ch2 result");
    drain();

    // R11: writes during a slow run are ignored
    wr(5'h01, 8'h08);
    ain[1] = 10'h301;
    wr(5'h00, 8'h41);                      // div8, start, channel 1
    wr(5'h02, 8'hFF);
    wr(5'h12, 8'h55);
    wr(5'h00, 8'h44);
    rd(5'h00, d); check("R11 busy readback", d[6], 1);
    cyc = 0;
    while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
    rd(5'h02, d); check("R11 mode write ignored", d, 8'h20);
    rd(5'h00, d); check("R11 ctrl0 write ignored", d, 8'h01);
    push_adc(1, 10'h301, 1'b1, "R11 result write ignored ch1");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule